// File: doc/BRIEF.md
# Slave Memory Endpoint for a Mesh Network Node

This block is the storage end of a slave node in a small two-dimensional mesh network. It takes packets from the router, unpacks them, and holds a small register memory. Any of five master nodes may write to the slave. Each master owns exactly one writable slot, and the data always goes into the slot of the master that sent it. A second bank of constant registers is loaded at reset from parameters. Masters can read these registers, but nothing can write them.

A read request produces a read-return packet. The slave builds the route offset of that packet itself, from the requester's index and its own position in the mesh. When the router reports busy, the slave holds one pending return. While that return is pending it takes no further read requests, but it still takes writes.

Top module: `slv_mem_node`

## Requirements
- R1: After reset the return-valid output is low, the request-ready output is high and all five writable slots read back as zero.
- R2: Packet layout, MSB first: opcode [24:23], source index [22:20], route [19:14], register address [13:10], two zero bits [9:8], data [7:0]. Opcode values: 00 none, 01 write, 10 read request, 11 read return.
- R3: A write with a source index from 0 to 4 stores its data in that master's slot. The address field of a write is ignored.
- R4: A read request for address k, with k from 0 to 3, returns the constant RO_BASE + k*RO_STEP. With default parameters this is 8'hA0 + k*8'h11.
- R5: A read request for address 4 returns the current contents of the requester's own slot.
- R6: The read-return packet appears on the cycle after the request is taken. It carries opcode 11, the slave's own index SLV_ID as source, the requested address echoed, zero pad bits, the data, and the return route.
- R7: Master i sits at mesh node 2*i, at row (2*i)/3 and column (2*i)%3. The route is {ysign, |dy|[1:0], xsign, |dx|[1:0]}, where dy and dx are the master's position minus the slave's. ysign=1 means north (row decreasing) and xsign=1 means west (column decreasing). The sign is 0 when the distance is 0.
- R8: While busy_i is high, a pending return stays on the output unchanged and request-ready is low. A read request offered in that state is dropped and produces no return.
- R9: A read request or write with a source index of 5 or more, and a read request for an address above 4, have no effect and produce no response.
- R10: A write is taken even while a read return is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_i | input | 25 | Incoming packet from router |
| pkt_vld_i | input | 1 | Incoming packet valid |
| rx_rdy_o | output | 1 | High when a read request can be taken |
| busy_i | input | 1 | Router cannot take the outgoing packet |
| pkt_o | output | 25 | Outgoing read-return packet |
| pkt_vld_o | output | 1 | Outgoing packet valid |

## Verification
The assertions check, on every cycle, that a return stays frozen under busy, that it leaves after one free cycle, that every valid output is a well-formed read return, and that accepted or out-of-range requests produce or suppress a return on the next cycle. Only the bench scenarios can show the stored contents, the constant values, the computed routes for each master, the dropping of a request under busy, and the isolation of each slot. The bench shows these by reading the slots back through the read path.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int SW    = 3;
  localparam int RW    = 6;
  localparam int PKT_W = 2 + SW + RW + AW + 2 + DW;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RQ   = 2'b10,
    OP_RT   = 2'b11
  } op_e;

  typedef struct packed {
    op_e           op;
    logic [SW-1:0] src;
    logic [RW-1:0] route;
    logic [AW-1:0] addr;
    logic [1:0]    pad;
    logic [DW-1:0] data;
  } pkt_t;

  // route offset from (my_r,my_c) toward master idx placed on even mesh nodes
  function automatic logic [RW-1:0] route_to(input int idx, input int my_r,
                                            input int my_c, input int mesh_w);
    int dy, dx;
    logic [1:0] ym, xm;
    dy = (2 * idx) / mesh_w - my_r;
    dx = (2 * idx) % mesh_w - my_c;
    ym = 2'((dy < 0) ? -dy : dy);
    xm = 2'((dx < 0) ? -dx : dx);
    return {(dy < 0), ym, (dx < 0), xm};
  endfunction
endpackage

// File: rtl/slv_rx_decode.sv
module slv_rx_decode
  import slv_pkg::*;
#(
  parameter int NUM_MST = 5,
  parameter int NUM_RO  = 4
) (
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             vld_i,
  input  logic             rq_rdy_i,
  output logic             wr_en_o,
  output logic [SW-1:0]    wr_slot_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             rq_en_o,
  output logic [SW-1:0]    rq_src_o,
  output logic [AW-1:0]    rq_addr_o
);
  localparam logic [SW-1:0] MST_LIM  = SW'(NUM_MST);
  localparam logic [AW-1:0] ADDR_MAX = AW'(NUM_RO);  // last valid: own slot

  pkt_t p;
  logic src_ok;

  always_comb begin
    p         = pkt_t'(pkt_i);
    src_ok    = p.src < MST_LIM;
    wr_en_o   = vld_i && p.op == OP_WR && src_ok;
    wr_slot_o = p.src;
    wr_data_o = p.data;
    rq_en_o   = vld_i && rq_rdy_i && p.op == OP_RQ && src_ok && p.addr <= ADDR_MAX;
    rq_src_o  = p.src;
    rq_addr_o = p.addr;
  end
endmodule

// File: rtl/slv_regfile.sv
module slv_regfile
  import slv_pkg::*;
#(
  parameter int            NUM_MST = 5,
  parameter int            NUM_RO  = 4,
  parameter logic [DW-1:0] RO_BASE = 8'hA0,
  parameter logic [DW-1:0] RO_STEP = 8'h11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_slot_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [SW-1:0] rd_src_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] slot_q [NUM_MST];
  logic [DW-1:0] ro     [NUM_RO];

  for (genvar k = 0; k < NUM_RO; k++) begin : g_ro
    assign ro[k] = RO_BASE + DW'(k) * RO_STEP;
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[m] <= '0;
      else if (wr_en_i && wr_slot_i == SW'(m))      slot_q[m] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(NUM_RO)) begin
      for (int m = 0; m < NUM_MST; m++)
        if (rd_src_i == SW'(m)) rd_data_o = slot_q[m];
    end else begin
      for (int k = 0; k < NUM_RO; k++)
        if (rd_addr_i == AW'(k)) rd_data_o = ro[k];
    end
  end
endmodule

// File: rtl/slv_tx.sv
module slv_tx
  import slv_pkg::*;
#(
  parameter int NUM_MST = 5,
  parameter int SLV_ID  = 0,
  parameter int MY_ROW  = 0,
  parameter int MY_COL  = 1,
  parameter int MESH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rq_en_i,
  input  logic [SW-1:0]    rq_src_i,
  input  logic [AW-1:0]    rq_addr_i,
  input  logic [DW-1:0]    rq_data_i,
  input  logic             busy_i,
  output logic             pend_o,
  output logic [PKT_W-1:0] pkt_o
);
  logic [RW-1:0] route_tab [NUM_MST];
  for (genvar m = 0; m < NUM_MST; m++) begin : g_rt
    assign route_tab[m] = route_to(m, MY_ROW, MY_COL, MESH_W);
  end

  logic [RW-1:0] route_sel;
  always_comb begin
    route_sel = '0;
    for (int m = 0; m < NUM_MST; m++)
      if (rq_src_i == SW'(m)) route_sel = route_tab[m];
  end

  logic pend_q;
  pkt_t out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      out_q  <= '0;
    end else if (rq_en_i) begin
      pend_q      <= 1'b1;
      out_q.op    <= OP_RT;
      out_q.src   <= SW'(SLV_ID);
      out_q.route <= route_sel;
      out_q.addr  <= rq_addr_i;
      out_q.pad   <= '0;
      out_q.data  <= rq_data_i;
    end else if (pend_q && !busy_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign pkt_o  = out_q;
endmodule

// File: rtl/slv_mem_node.sv
module slv_mem_node
  import slv_pkg::*;
#(
  parameter int            NUM_MST = 5,
  parameter int            NUM_RO  = 4,
  parameter int            SLV_ID  = 0,
  parameter int            MY_ROW  = 0,
  parameter int            MY_COL  = 1,
  parameter int            MESH_W  = 3,
  parameter logic [DW-1:0] RO_BASE = 8'hA0,
  parameter logic [DW-1:0] RO_STEP = 8'h11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             pkt_vld_i,
  output logic             rx_rdy_o,
  input  logic             busy_i,
  output logic [PKT_W-1:0] pkt_o,
  output logic             pkt_vld_o
);
  logic          wr_en, rq_en, pend;
  logic [SW-1:0] wr_slot, rq_src;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW-1:0] rq_addr;

  slv_rx_decode #(.NUM_MST(NUM_MST), .NUM_RO(NUM_RO)) u_dec (
    .pkt_i(pkt_i), .vld_i(pkt_vld_i), .rq_rdy_i(!pend),
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .wr_data_o(wr_data),
    .rq_en_o(rq_en), .rq_src_o(rq_src), .rq_addr_o(rq_addr)
  );

  slv_regfile #(.NUM_MST(NUM_MST), .NUM_RO(NUM_RO),
                .RO_BASE(RO_BASE), .RO_STEP(RO_STEP)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_data_i(wr_data),
    .rd_src_i(rq_src), .rd_addr_i(rq_addr), .rd_data_o(rd_data)
  );

  slv_tx #(.NUM_MST(NUM_MST), .SLV_ID(SLV_ID), .MY_ROW(MY_ROW),
           .MY_COL(MY_COL), .MESH_W(MESH_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rq_en_i(rq_en), .rq_src_i(rq_src), .rq_addr_i(rq_addr), .rq_data_i(rd_data),
    .busy_i(busy_i), .pend_o(pend), .pkt_o(pkt_o)
  );

  assign rx_rdy_o  = !pend;
  assign pkt_vld_o = pend;
endmodule

// File: rtl/slv_mem_node_chk.sv
module slv_mem_node_chk
  import slv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PKT_W-1:0] pkt_i,
  input logic             pkt_vld_i,
  input logic             rx_rdy_o,
  input logic             busy_i,
  input logic [PKT_W-1:0] pkt_o,
  input logic             pkt_vld_o
);
  logic in_rq, in_good, in_bad;
  assign in_rq   = pkt_vld_i && pkt_i[24:23] == 2'b10;
  assign in_good = in_rq && rx_rdy_o && pkt_i[22:20] < 3'd5 && pkt_i[13:10] <= 4'd4;
  assign in_bad  = in_rq && (pkt_i[22:20] >= 3'd5 || pkt_i[13:10] > 4'd4);

  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o && busy_i |=> pkt_vld_o && $stable(pkt_o));  // R8
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o && !busy_i && !in_good |=> !pkt_vld_o);  // R6
  AST_RET_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> pkt_o[24:23] == 2'b11 && pkt_o[9:8] == 2'b00);  // R2
  AST_RQ_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_good |=> pkt_vld_o && pkt_o[13:10] == $past(pkt_i[13:10]));  // R6
  AST_BAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_vld_o && in_bad |=> !pkt_vld_o);  // R9
  AST_NO_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_vld_o && !in_rq |=> !pkt_vld_o);  // R9
  AST_RDY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o && busy_i |=> !rx_rdy_o);  // R8
endmodule

bind slv_mem_node slv_mem_node_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_i(pkt_i), .pkt_vld_i(pkt_vld_i),
  .rx_rdy_o(rx_rdy_o), .busy_i(busy_i), .pkt_o(pkt_o), .pkt_vld_o(pkt_vld_o)
);

// File: tb/sim_slv_mem_node.sv
`timescale 1ns/1ps
module sim_slv_mem_node;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] pkt_i = '0;
  logic        pkt_vld_i = 1'b0;
  logic        busy = 1'b0;
  logic        rx_rdy;
  logic [24:0] pkt_o;
  logic        pkt_vld_o;

  int checks = 0;
  int errors = 0;
  logic [24:0] expq[$];
  logic [7:0]  slots [5];
  bit done = 0;

  always #2.5 clk = ~clk;

  slv_mem_node u0 (
    .clk_i(clk), .rst_ni(rst_n), .pkt_i(pkt_i), .pkt_vld_i(pkt_vld_i),
    .rx_rdy_o(rx_rdy), .busy_i(busy), .pkt_o(pkt_o), .pkt_vld_o(pkt_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7: route table written from master placement, slave at row 0 col 1
  function automatic logic [5:0] exp_route(input int m);
    case (m)
      0: return 6'b000_101;  // same row, one west
      1: return 6'b000_001;  // one east
      2: return 6'b001_000;  // one south
      3: return 6'b010_101;  // two south, one west
      default: return 6'b010_001;  // two south, one east
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int src, input int addr);
    if (addr == 4) return slots[src];           // R5
    return 8'hA0 + 8'(addr) * 8'h11;            // R4
  endfunction

  task automatic send(input logic [1:0] op, input logic [2:0] src,
                      input logic [3:0] addr, input logic [7:0] data);
    @(posedge clk); #1;
    pkt_i = {op, src, 6'b0, addr, 2'b00, data};
    pkt_vld_i = 1'b1;
    @(posedge clk); #1;
    pkt_vld_i = 1'b0;
    pkt_i = '0;
  endtask

  task automatic wr(input int src, input logic [3:0] addr, input logic [7:0] d);
    send(2'b01, 3'(src), addr, d);
    if (src < 5) slots[src] = d;  // R3
  endtask

  task automatic rq(input int src, input int addr);
    expq.push_back({2'b11, 3'd0, exp_route(src), 4'(addr), 2'b00,
                    exp_data(src, addr)});  // R6
    send(2'b10, 3'(src), 4'(addr), 8'h5A);
    wait_idle();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20 && expq.size() != 0; i++) @(posedge clk);
    @(posedge clk);
  endtask

  // monitor: pop on each transfer cycle
  always @(negedge clk) begin
    if (rst_n && pkt_vld_o && !busy) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected return", 32'(pkt_o), 32'h0);
      else begin
        logic [24:0] e;
        e = expq.pop_front();
        chk(pkt_o == e, "R6/R7 return packet", 32'(pkt_o), 32'(e));
      end
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) slots[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(pkt_vld_o == 1'b0, "R1 vld after reset", 32'(pkt_vld_o), 0);
    chk(rx_rdy == 1'b1, "R1 rdy after reset", 32'(rx_rdy), 1);
    rst_n = 1'b1;
    // R1 slots read zero
    for (int m = 0; m < 5; m++) rq(m, 4);
    // R4 constant bank, R7 routes for every master
    for (int a = 0; a < 4; a++) rq(a, a);
    rq(4, 3);
    // R3 writes land in the sender's slot; address ignored
    wr(0, 4'd9, 8'h11);
    wr(1, 4'd0, 8'h22);
    wr(2, 4'd4, 8'h33);
    wr(3, 4'd2, 8'h44);
    wr(4, 4'd15, 8'h55);
    for (int m = 0; m < 5; m++) rq(m, 4);
    // R9 bad source on write and read, bad address
    wr(6, 4'd4, 8'hEE);
    send(2'b10, 3'd5, 4'd0, 8'h0);
    send(2'b10, 3'd1, 4'd5, 8'h0);
    send(2'b10, 3'd2, 4'd15, 8'h0);
    repeat (3) @(posedge clk);
    #1;
    chk(pkt_vld_o == 1'b0, "R9 no response to bad request", 32'(pkt_vld_o), 0);
    for (int m = 0; m < 5; m++) rq(m, 4);  // R9 slots untouched by bad write
    // R8 busy hold, R10 write during pending
    @(posedge clk); #1;
    busy = 1'b1;
    expq.push_back({2'b11, 3'd0, exp_route(3), 4'd1, 2'b00, exp_data(3, 1)});
    send(2'b10, 3'd3, 4'd1, 8'h0);
    #1;
    chk(pkt_vld_o == 1'b1, "R8 pending return visible", 32'(pkt_vld_o), 1);
    chk(rx_rdy == 1'b0, "R8 rdy low while pending", 32'(rx_rdy), 0);
    begin
      logic [24:0] held;
      held = pkt_o;
      send(2'b10, 3'd0, 4'd2, 8'h0);  // dropped
      wr(2, 4'd0, 8'h77);             // R10 accepted
      repeat (4) @(posedge clk);
      #1;
      chk(pkt_o == held && pkt_vld_o, "R8 return held stable", 32'(pkt_o), 32'(held));
    end
    @(posedge clk); #1;
    busy = 1'b0;
    wait_idle();
    repeat (3) @(posedge clk);
    #1;
    chk(pkt_vld_o == 1'b0, "R8 dropped request gave no return", 32'(pkt_vld_o), 0);
    chk(rx_rdy == 1'b1, "R8 rdy back after send", 32'(rx_rdy), 1);
    rq(2, 4);  // R10 readback 77
    rq(1, 4);
    chk(expq.size() == 0, "R6 all returns seen", 32'(expq.size()), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule